// File: doc/BRIEF.md
# Receive Packet Drain Engine

This block sits on the host side of an external Ethernet MAC and empties the MAC's receive buffer. It reaches the MAC over an indexed register bus. A write to the address port selects a register, and later accesses to the data port read or write that register. The data port is 8, 16 or 32 bits wide, chosen by a two-bit mode input. A pulse on `start` asks the engine to look for received traffic. It reads the interrupt status register and stops at once if the packet-received flag (bit 0) is clear. Otherwise it clears the flag and drains frames until the buffer reports that no more are ready.

Each pass of the drain loop has these steps:
- Peek the ready byte through the non-incrementing read register.
- Fetch the four-byte header (status word, then length word) through the auto-incrementing read register.
- Read the payload in whole bus words.
- Classify the frame.

Good frames leave as a byte stream with valid and last flags, followed by a one-cycle done pulse. Bad frames are still read out of the MAC so the buffer pointer moves past them, but none of their bytes appear on the stream, and a drop pulse marks them. A ready value that is neither 0 nor 1 is a fatal condition: the engine turns reception off in the MAC, writes the interrupt-stop value and halts with a sticky error flag.

Top module: `rxd_drain`

## Requirements
- R1: On `start` while idle, the engine writes address 0xFE and reads the data port. If bit 0 of that value is 0, the engine returns to idle with no further data-port access and no output. If bit 0 is 1, it writes 0x01 to the data port (0xFE still selected), which clears only that bit.
- R2: Each loop pass selects address 0xF0, does one dummy data read, then reads the ready byte and uses only its bits 1:0. A masked value of 0 (for example a raw byte of 0x04) ends the drain with `fatal` low. A masked value of 1 (for example a raw byte of 0x05) means a frame follows.
- R3: A masked ready value of 2 or 3 makes the engine write 0x00 to register 0x05 and then 0x80 to register 0xFE. It then goes idle with `fatal` high, and `fatal` stays high until the next accepted `start`.
- R4: For a frame, the engine selects address 0xF2 and reads four header bytes in little-endian order. Bytes 0 and 1 are the status, bytes 2 and 3 are the length. In 32-bit mode they come from one read with the status in the low half.
- R5: `busMode` sets the data-port width: 00 is 16-bit, 01 is 32-bit, 10 is 8-bit, and 11 falls back to 8-bit. Only the low bytes of a read are used when the port is narrower than 32 bits.
- R6: The payload is read as ceil(length / port-bytes) data reads from 0xF2. Pad bytes in the last word are discarded, and length 0 reads no payload.
- R7: A frame is bad when status AND 0xBF00 is nonzero. Any one of bits 8, 9 or 15 makes it bad, and status bit 14 alone does not.
- R8: A frame is bad when its length is below 64 or above `MAX_LEN`. Lengths of exactly 64 and exactly `MAX_LEN` are accepted.
- R9: An oversize length (above `MAX_LEN`) also gives a one-cycle `resetReq` pulse, and the drain carries on with the next frame.
- R10: A good frame's payload bytes appear in buffer order on `outData` with `outValid`. `outLast` marks the final byte, and one `frameDone` pulse follows.
- R11: A bad frame is fully read from the MAC, but `outValid` stays low for all of its bytes and one `frameDrop` pulse replaces `frameDone`.
- R12: One activation drains every consecutive ready frame until a ready value of 0 or a fatal value is seen, and the buffer read pointer is left at the ready byte that ended the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Drain request pulse, accepted only while idle |
| busMode | input | 2 | Data-port width select |
| busSelAddr | output | 1 | 1: access targets the address port, 0: the data port |
| busWr | output | 1 | Write strobe for this cycle |
| busRd | output | 1 | Read strobe for this cycle (data port) |
| busWrData | output | 32 | Write value (register index or data byte) |
| busRdData | input | 32 | Read value returned in the same cycle |
| outValid | output | 1 | Payload byte of a good frame is present |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final byte of the frame |
| frameDone | output | 1 | Pulse after a good frame |
| frameDrop | output | 1 | Pulse after a bad frame |
| resetReq | output | 1 | Pulse asking for a MAC reset (oversize length) |
| fatal | output | 1 | Sticky fatal ready-byte error |
| busy | output | 1 | Engine is not idle |

## Verification
The bench builds the engine with `MAX_LEN` lowered to 96 and `MIN_LEN` left at 64. Oversize, boundary and short frames therefore stay a few dozen bytes long, and many bursts fit in the run. Because the port width is a run-time input, one build covers all four mode codes. The lengths are chosen so that the 2-byte and 4-byte port cases see every pad count in the last word. A bench model of the MAC buffer tracks the read pointer, so the word rounding and the reading of bad frames out of the buffer show up as pointer positions.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int BUS_W = 32;
  localparam int LEN_W = 16;

  typedef enum logic [4:0] {
    ST_IDLE, ST_ISR_SEL, ST_ISR_RD, ST_ISR_CLR,
    ST_PEEK_SEL, ST_PEEK_DUMMY, ST_PEEK_RD,
    ST_CMD_SEL, ST_HDR_RD, ST_CLASS, ST_PAY_RD, ST_EMIT, ST_FEND,
    ST_FAT_SEL1, ST_FAT_W1, ST_FAT_SEL2, ST_FAT_W2
  } drainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrHdr;
    logic capHdr;
    logic startPay;
    logic loadWord;
    logic shiftByte;
  } dpCtl_t;

  // datapath view returned to control
  typedef struct packed {
    logic       isrSet;
    logic [1:0] rdyVal;
    logic       hdrLastRead;
    logic       lenZero;
    logic       oversize;
    logic       badFrame;
    logic       lastByte;
    logic       wordLastByte;
  } dpStat_t;

  // bytes per data-port access for a mode code
  function automatic logic [2:0] portBytes(input logic [1:0] mode);
    case (mode)
      2'b00:   portBytes = 3'd2;
      2'b01:   portBytes = 3'd4;
      default: portBytes = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rxd_pkg::*;
#(
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1536,
  parameter logic [15:0] STATUS_MASK = 16'hBF00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busMode,
  input  logic [BUS_W-1:0] busRdData,
  input  dpCtl_t           ctl,
  output dpStat_t          stat,
  output logic [7:0]       outData
);

  logic [31:0]      hdrReg;
  logic [2:0]       hdrCnt;
  logic [LEN_W-1:0] lenRem;
  logic [BUS_W-1:0] wordReg;
  logic [2:0]       wordCnt;
  logic             badReg;
  logic [2:0]       bpw;
  logic [15:0]      statusWord;
  logic [LEN_W-1:0] lenWord;
  logic             badNow;

  assign bpw        = portBytes(busMode);
  assign statusWord = hdrReg[15:0];
  assign lenWord    = hdrReg[31:16];
  assign badNow     = (|(statusWord & STATUS_MASK)) ||
                      (lenWord < LEN_W'(MIN_LEN)) || stat.oversize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg <= '0;
      hdrCnt <= '0;
    end else if (ctl.clrHdr) begin
      hdrCnt <= '0;
    end else if (ctl.capHdr) begin
      case (bpw)
        3'd1:    hdrReg[hdrCnt[1:0]*8 +: 8]  <= busRdData[7:0];
        3'd2:    hdrReg[hdrCnt[1]*16 +: 16]  <= busRdData[15:0];
        default: hdrReg                      <= busRdData[31:0];
      endcase
      hdrCnt <= hdrCnt + bpw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenRem  <= '0;
      wordReg <= '0;
      wordCnt <= '0;
      badReg  <= 1'b0;
    end else begin
      if (ctl.startPay) begin
        lenRem <= lenWord;
        badReg <= badNow;
      end else if (ctl.shiftByte) begin
        lenRem <= lenRem - 1'b1;
      end
      if (ctl.loadWord) begin
        wordReg <= busRdData;
        wordCnt <= (lenRem < LEN_W'(bpw)) ? lenRem[2:0] : bpw;
      end else if (ctl.shiftByte) begin
        wordReg <= wordReg >> 8;
        wordCnt <= wordCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stat.isrSet       = busRdData[0];
    stat.rdyVal       = busRdData[1:0];
    stat.hdrLastRead  = ({1'b0, hdrCnt} + {1'b0, bpw}) >= 4'd4;
    stat.lenZero      = (lenWord == '0);
    stat.oversize     = (lenWord > LEN_W'(MAX_LEN));
    stat.badFrame     = badReg;
    stat.lastByte     = (lenRem == LEN_W'(1));
    stat.wordLastByte = (wordCnt == 3'd1);
  end

  assign outData = wordReg[7:0];

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter logic [7:0] REG_ISR  = 8'hFE,
  parameter logic [7:0] REG_RXC  = 8'h05,
  parameter logic [7:0] REG_PEEK = 8'hF0,
  parameter logic [7:0] REG_READ = 8'hF2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  dpStat_t          stat,
  output dpCtl_t           ctl,
  output logic             busSelAddr,
  output logic             busWr,
  output logic             busRd,
  output logic [BUS_W-1:0] busWrData,
  output logic             outValid,
  output logic             outLast,
  output logic             frameDone,
  output logic             frameDrop,
  output logic             resetReq,
  output logic             fatal,
  output logic             busy
);

  drainState_t state, stateNxt;
  logic        fatalReg;
  logic        enterFatal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fatalReg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && start) fatalReg <= 1'b0;
      else if (enterFatal)           fatalReg <= 1'b1;
    end
  end

  always_comb begin
    stateNxt   = state;
    ctl        = '0;
    busSelAddr = 1'b0;
    busWr      = 1'b0;
    busRd      = 1'b0;
    busWrData  = '0;
    enterFatal = 1'b0;
    case (state)
      ST_IDLE:      if (start) stateNxt = ST_ISR_SEL;
      ST_ISR_SEL: begin
        busSelAddr = 1'b1; busWr = 1'b1; busWrData[7:0] = REG_ISR;
        stateNxt = ST_ISR_RD;
      end
      ST_ISR_RD: begin
        busRd = 1'b1;
        stateNxt = stat.isrSet ? ST_ISR_CLR : ST_IDLE;
      end
      ST_ISR_CLR: begin
        busWr = 1'b1; busWrData[7:0] = 8'h01;
        stateNxt = ST_PEEK_SEL;
      end
      ST_PEEK_SEL: begin
        busSelAddr = 1'b1; busWr = 1'b1; busWrData[7:0] = REG_PEEK;
        stateNxt = ST_PEEK_DUMMY;
      end
      ST_PEEK_DUMMY: begin
        busRd = 1'b1;
        stateNxt = ST_PEEK_RD;
      end
      ST_PEEK_RD: begin
        busRd = 1'b1;
        case (stat.rdyVal)
          2'd0:    stateNxt = ST_IDLE;
          2'd1:    stateNxt = ST_CMD_SEL;
          default: stateNxt = ST_FAT_SEL1;
        endcase
      end
      ST_CMD_SEL: begin
        busSelAddr = 1'b1; busWr = 1'b1; busWrData[7:0] = REG_READ;
        ctl.clrHdr = 1'b1;
        stateNxt = ST_HDR_RD;
      end
      ST_HDR_RD: begin
        busRd = 1'b1; ctl.capHdr = 1'b1;
        if (stat.hdrLastRead) stateNxt = ST_CLASS;
      end
      ST_CLASS: begin
        ctl.startPay = 1'b1;
        stateNxt = stat.lenZero ? ST_FEND : ST_PAY_RD;
      end
      ST_PAY_RD: begin
        busRd = 1'b1; ctl.loadWord = 1'b1;
        stateNxt = ST_EMIT;
      end
      ST_EMIT: begin
        ctl.shiftByte = 1'b1;
        if (stat.lastByte)          stateNxt = ST_FEND;
        else if (stat.wordLastByte) stateNxt = ST_PAY_RD;
      end
      ST_FEND:      stateNxt = ST_PEEK_SEL;
      ST_FAT_SEL1: begin
        busSelAddr = 1'b1; busWr = 1'b1; busWrData[7:0] = REG_RXC;
        stateNxt = ST_FAT_W1;
      end
      ST_FAT_W1: begin
        busWr = 1'b1; busWrData[7:0] = 8'h00;
        stateNxt = ST_FAT_SEL2;
      end
      ST_FAT_SEL2: begin
        busSelAddr = 1'b1; busWr = 1'b1; busWrData[7:0] = REG_ISR;
        stateNxt = ST_FAT_W2;
      end
      ST_FAT_W2: begin
        busWr = 1'b1; busWrData[7:0] = 8'h80;
        enterFatal = 1'b1;
        stateNxt = ST_IDLE;
      end
      default:      stateNxt = ST_IDLE;
    endcase
  end

  assign outValid  = (state == ST_EMIT) && !stat.badFrame;
  assign outLast   = outValid && stat.lastByte;
  assign frameDone = (state == ST_FEND) && !stat.badFrame;
  assign frameDrop = (state == ST_FEND) && stat.badFrame;
  assign resetReq  = (state == ST_CLASS) && stat.oversize;
  assign fatal     = fatalReg;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/rxd_drain.sv
module rxd_drain
  import rxd_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1536
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       busMode,
  output logic             busSelAddr,
  output logic             busWr,
  output logic             busRd,
  output logic [BUS_W-1:0] busWrData,
  input  logic [BUS_W-1:0] busRdData,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             frameDone,
  output logic             frameDrop,
  output logic             resetReq,
  output logic             fatal,
  output logic             busy
);

  dpCtl_t  ctl;
  dpStat_t stat;

  rxd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .ctl(ctl),
    .busSelAddr(busSelAddr), .busWr(busWr), .busRd(busRd), .busWrData(busWrData),
    .outValid(outValid), .outLast(outLast), .frameDone(frameDone),
    .frameDrop(frameDrop), .resetReq(resetReq), .fatal(fatal), .busy(busy)
  );

  rxd_datapath #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .busMode(busMode), .busRdData(busRdData),
    .ctl(ctl), .stat(stat), .outData(outData)
  );

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busWr,
  input logic busRd,
  input logic outValid,
  input logic outLast,
  input logic frameDone,
  input logic frameDrop,
  input logic resetReq,
  input logic fatal,
  input logic busy
);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $countones({busWr, busRd}) <= 1);                          // R4
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);                                     // R10
  AST_VALID_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);                                        // R10
  AST_DONE_DROP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameDone, frameDrop, outValid}));               // R11
  AST_RESET_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !outValid && !frameDone);                     // R9
  AST_FATAL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    fatal |-> !busy);                                          // R3
  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fatal && !start |=> fatal);                                // R3
  AST_DONE_THEN_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);                                 // R10

endmodule

bind rxd_drain rxd_checker i_rxd_checker (
  .clk(clk), .rstN(rstN), .start(start), .busWr(busWr), .busRd(busRd),
  .outValid(outValid), .outLast(outLast), .frameDone(frameDone),
  .frameDrop(frameDrop), .resetReq(resetReq), .fatal(fatal), .busy(busy)
);

// File: tb/test_rxd_drain.sv
module test_rxd_drain;

  localparam int MAXL = 96;
  localparam int MINL = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  busMode = 2'b00;
  logic        busSelAddr, busWr, busRd;
  logic [31:0] busWrData, busRdData;
  logic        outValid, outLast, frameDone, frameDrop, resetReq, fatal, busy;
  logic [7:0]  outData;

  always #5 clk = ~clk;

  rxd_drain #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) i_rxd_drain (
    .clk(clk), .rstN(rstN), .start(start), .busMode(busMode),
    .busSelAddr(busSelAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .frameDone(frameDone), .frameDrop(frameDrop), .resetReq(resetReq),
    .fatal(fatal), .busy(busy)
  );

  // MAC model
  logic [7:0] mem [0:2047];
  logic [7:0] idx, isrReg, rxcReg, lastIsrWr;
  int         ptr;
  int         dataAcc;

  function automatic int wBytes(input logic [1:0] m);
    return (m == 2'b00) ? 2 : (m == 2'b01) ? 4 : 1;
  endfunction

  always_comb begin
    case (idx)
      8'hFE:   busRdData = {24'd0, isrReg};
      8'hF0:   busRdData = {24'd0, mem[ptr]};
      8'hF2:   busRdData = {mem[ptr+3], mem[ptr+2], mem[ptr+1], mem[ptr]};
      default: busRdData = 32'd0;
    endcase
  end

  always @(posedge clk) begin
    if ((busWr || busRd) && !busSelAddr && idx != 8'hFE) dataAcc <= dataAcc + 1;
    if (busWr && busSelAddr) idx <= busWrData[7:0];
    if (busWr && !busSelAddr) begin
      if (idx == 8'hFE) begin
        isrReg    <= isrReg & ~busWrData[7:0];
        lastIsrWr <= busWrData[7:0];
      end
      if (idx == 8'h05) rxcReg <= busWrData[7:0];
    end
    if (busRd && !busSelAddr && idx == 8'hF2) ptr <= ptr + wBytes(busMode);
  end

  // output monitor
  logic [8:0] gotQ[$];
  logic [8:0] expQ[$];
  int gotDone, gotDrop, gotReset;
  always @(negedge clk) begin
    if (outValid) gotQ.push_back({outLast, outData});
    if (frameDone) gotDone = gotDone + 1;
    if (frameDrop) gotDrop = gotDrop + 1;
    if (resetReq)  gotReset = gotReset + 1;
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit isBad(input logic [7:0] stHi, input int len);
    return ((stHi & 8'hBF) != 8'h00) || (len < MINL) || (len > MAXL);
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one activation: build buffer, compute expectations, run, compare
  task automatic runBurst(input logic [1:0] mode, input int nFr,
                          input int lens[4], input logic [7:0] stHi[4],
                          input logic [7:0] rdyByte, input logic [7:0] term,
                          input logic [7:0] isrInit, input string tag);
    int p, w, expDone, expDrop, expReset, expEnd, wait0;
    bit expFatal, drained;
    logic [7:0] b;
    w = wBytes(mode);
    p = 0; expDone = 0; expDrop = 0; expReset = 0;
    expQ.delete();
    @(negedge clk);
    for (int f = 0; f < nFr; f++) begin
      mem[p] = rdyByte; mem[p+1] = stHi[f];
      mem[p+2] = lens[f][7:0]; mem[p+3] = lens[f][15:8];
      p += 4;
      for (int k = 0; k < lens[f]; k++) begin
        b = 8'($urandom);
        mem[p+k] = b;
        if (!isBad(stHi[f], lens[f])) expQ.push_back({(k == lens[f]-1), b});
      end
      for (int k = lens[f]; k < ((lens[f] + w - 1) / w) * w; k++) mem[p+k] = 8'hEE;
      p += ((lens[f] + w - 1) / w) * w;
      if (isBad(stHi[f], lens[f])) expDrop++; else expDone++;
      if (lens[f] > MAXL) expReset++;
    end
    mem[p] = term; mem[p+1] = 8'h55; mem[p+2] = 8'h55; mem[p+3] = 8'h55;
    drained = isrInit[0];
    expEnd = drained ? p : 0;
    expFatal = drained && (term[1:0] > 2'd1);
    if (!drained) expQ.delete();
    if (!drained) begin expDone = 0; expDrop = 0; expReset = 0; end
    ptr = 0; isrReg = isrInit; rxcReg = 8'hAA; lastIsrWr = 8'h00; dataAcc = 0;
    busMode = mode;
    gotQ.delete(); gotDone = 0; gotDrop = 0; gotReset = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait0 = 0;
    while (busy) begin
      @(negedge clk);
      if (cycles > 150000) begin
        chk(0, "WATCHDOG", tag, cycles, 150000);
        finishRun();
      end
    end
    @(negedge clk);
    // R10 R11 stream of good payload bytes incl. last flag
    chk(gotQ.size() == expQ.size(), "R10", {tag, " byte count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      if (gotQ[i] !== expQ[i]) begin
        chk(0, "R10", {tag, " byte"}, int'(gotQ[i]), int'(expQ[i]));
        break;
      end
    chk(gotDone == expDone, "R10", {tag, " frameDone"}, gotDone, expDone);
    chk(gotDrop == expDrop, "R11", {tag, " frameDrop"}, gotDrop, expDrop);
    chk(gotReset == expReset, "R9", {tag, " resetReq"}, gotReset, expReset);
    chk(ptr == expEnd, "R12", {tag, " read pointer (R6 rounding)"}, ptr, expEnd);
    chk(isrReg == (isrInit & 8'hFE), "R1", {tag, " isr after"}, isrReg, isrInit & 8'hFE);
    chk(fatal == expFatal, "R3", {tag, " fatal"}, fatal, expFatal);
    if (expFatal) begin
      chk(rxcReg == 8'h00, "R3", {tag, " rx control"}, rxcReg, 0);
      chk(lastIsrWr == 8'h80, "R3", {tag, " isr write"}, lastIsrWr, 8'h80);
    end else begin
      chk(rxcReg == 8'hAA, "R2", {tag, " rx control untouched"}, rxcReg, 8'hAA);
    end
    if (!drained) chk(dataAcc == 0, "R1", {tag, " no drain access"}, dataAcc, 0);
  endtask

  initial begin
    int lens[4];
    logic [7:0] sts[4];
    int r;
    void'($urandom(32'h5EED_0042));
    dataAcc = 0;
    ptr = 0;
    idx = 8'h00; isrReg = 8'h00; rxcReg = 8'hAA; lastIsrWr = 8'h00;
    gotDone = 0; gotDrop = 0; gotReset = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !outValid && !fatal && !busRd && !busWr, "R1", "reset state",
        {busy, outValid, fatal, busRd, busWr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runBurst(2'b00, 1, '{64, 0, 0, 0}, '{8'h00, 0, 0, 0}, 8'h01, 8'h00, 8'h40, "R1 isr clear");
    runBurst(2'b00, 2, '{64, MAXL, 0, 0}, '{8'h00, 8'h40, 0, 0}, 8'h01, 8'h00, 8'h41, "R8 bounds 16b");
    runBurst(2'b01, 2, '{MINL-1, MAXL+1, 0, 0}, '{8'h00, 8'h00, 0, 0}, 8'h01, 8'h04, 8'h01, "R8 R9 out of range 32b");
    runBurst(2'b10, 3, '{70, 71, 72, 0}, '{8'h01, 8'h02, 8'h80, 0}, 8'h01, 8'h00, 8'h01, "R7 status bits 8b");
    runBurst(2'b11, 2, '{65, 0, 0, 0}, '{8'h00, 8'h00, 0, 0}, 8'h05, 8'h00, 8'h01, "R5 mode 11 R2 ready 05");
    runBurst(2'b01, 1, '{67, 0, 0, 0}, '{8'h00, 0, 0, 0}, 8'h01, 8'h02, 8'h01, "R3 fatal 2");
    runBurst(2'b00, 1, '{66, 0, 0, 0}, '{8'h00, 0, 0, 0}, 8'h01, 8'h03, 8'h01, "R3 fatal 3");
    runBurst(2'b01, 4, '{65, 66, 67, 68}, '{0, 0, 0, 0}, 8'h01, 8'h00, 8'h01, "R4 R6 pads 32b");
    runBurst(2'b00, 0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 8'h01, 8'h00, 8'h01, "R2 empty");

    // constrained random bursts
    for (int t = 0; t < 40; t++) begin
      for (int f = 0; f < 4; f++) begin
        r = $urandom % 8;
        if (r == 0)      lens[f] = $urandom % MINL;
        else if (r == 1) lens[f] = MAXL + 1 + ($urandom % 20);
        else             lens[f] = MINL + ($urandom % (MAXL - MINL + 1));
        r = $urandom % 8;
        case (r)
          0: sts[f] = 8'h01;
          1: sts[f] = 8'h02;
          2: sts[f] = 8'h80;
          3: sts[f] = 8'h40;
          default: sts[f] = 8'h00;
        endcase
      end
      r = $urandom % 6;
      runBurst(2'($urandom), 1 + ($urandom % 4), lens, sts, 8'h01,
               (r == 0) ? 8'h02 : (r == 1) ? 8'h07 : (r == 2) ? 8'h04 : 8'h00,
               8'h01, "R12 random");
    end
    finishRun();
  end

endmodule